// File: doc/BRIEF.md
# Dual-ID Two-Wire Slave Controller

This block is a two-wire bus slave that answers two slave identifiers sharing one 3-bit device-select field. Identifier `1010b` reaches a 32K x 8 byte memory port and identifier `1101b` reaches a small real-time-clock register port. A single protocol engine serves both targets. Each target keeps its own address pointer, and that pointer persists across transactions, so software can read clock registers without losing its place in memory.

SCL and SDA are sampled in the system clock domain through a two-flop synchroniser and a stability filter. The engine finds start and stop conditions, shifts bytes MSB first, drives acknowledge and read data through an open-drain enable, and issues single-cycle read and write strobes to the two ports. A read port returns its data on the cycle after its read strobe.

Top module: `dual_id_twi_slave`

## Requirements
- R1: The first byte after a start is decoded as bits 7..4 identifier, bits 3..1 device select and bit 0 direction (1 = read). Identifier 1010b selects the memory target and 1101b selects the RTC target, and a matching byte is acknowledged by pulling SDA low in the ninth clock.
- R2: A first byte whose device-select bits differ from `dev_sel`, or whose identifier is neither of the two, is not acknowledged and causes no strobe until the next start.
- R3: A memory write takes an address high byte and then a low byte. Bit 7 of the high byte is ignored, the pointer is 15 bits wide, and it wraps from 7FFFh to 0000h.
- R4: An RTC write takes one address byte. Its low four bits load the RTC pointer and its upper four bits are ignored.
- R5: The active pointer advances by one after every data byte, written or read. An access to one target never changes the other target's pointer.
- R6: A write strobe is raised only after the eighth data bit has been sampled. A start or stop before that bit discards the byte and raises no strobe.
- R7: A read starts at the current pointer and sends another byte each time the master acknowledges. A not-acknowledge ends the read and SDA stays released. Read data is taken on the cycle after the read strobe.
- R8: A start at any point aborts the current operation and re-arms identifier matching, so an address-only write followed by a repeated start and a read works as a random read.
- R9: `sda_oe` changes only while SCL is low. Data is sampled while SCL is high and sent MSB first.
- R10: While `pwr_good` is low the bus is ignored: SDA is released and no byte is acknowledged.
- R11: After reset `sda_oe` is 0, both pointers are 0 and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Supply good; bus ignored while low |
| dev_sel | input | 3 | Device-select strap value |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe | output | 1 | 1 = pull SDA low |
| mem_addr | output | 15 | Memory pointer |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_rd` |
| rtc_addr | output | 4 | RTC register pointer |
| rtc_wr | output | 1 | RTC write strobe |
| rtc_rd | output | 1 | RTC read strobe |
| rtc_rdata | input | 8 | RTC read data, valid the cycle after `rtc_rd` |
| wr_data | output | 8 | Write data for either target |

## Verification
A start condition and the sampling of a data bit can both arrive while a byte is only partly shifted in, and the start must win so that no write strobe escapes. The bench sends four bits of a data byte, issues a repeated start, and then checks that the memory write-strobe count did not move and that the addressed location still reads back its untouched value. A second overlap is the pointer increment that follows a write strobe and the read strobe of a later access to the other target. The bench interleaves RTC writes between memory reads and compares the memory pointer port with the address it predicts.

// File: rtl/twi_pkg.sv
// Shared types for the dual-identifier two-wire slave.
// Assumes: one system clock domain, protocol byte width of 8.
package twi_pkg;
    localparam int BYTE_W = 8;
    localparam logic [3:0] ID_MEM = 4'b1010;
    localparam logic [3:0] ID_RTC = 4'b1101;

    typedef enum logic [2:0] {
        PH_IDLE, PH_RX, PH_ACK, PH_LOAD, PH_FETCH, PH_TX, PH_MACK
    } phase_t;

    typedef enum logic [1:0] {
        ST_DEV, ST_AHI, ST_ALO, ST_DATA
    } stage_t;
endpackage

// File: rtl/twi_line_filter.sv
// Synchronises one bus line and lets a new level through only after it
// has been stable for STABLE system clocks.
// Assumes: idle bus level is high, STABLE >= 1.
module twi_line_filter #(
    parameter int STABLE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(STABLE + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    // Two-flop synchroniser followed by a stability counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            clean  <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw};
            if (sync_q[1] == clean) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(STABLE - 1)) begin
                clean <= sync_q[1];
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/twi_bus_events.sv
// Turns filtered SCL/SDA into single-cycle edge and condition pulses.
// Assumes: inputs are already synchronous and glitch free.
module twi_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_q, sda_q;

    // Remember the previous line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    // Edges of SCL; SDA moving while SCL stays high marks start or stop.
    always_comb begin
        scl_rise  = scl & ~scl_q;
        scl_fall  = ~scl & scl_q;
        start_evt = scl & scl_q & sda_q & ~sda;
        stop_evt  = scl & scl_q & ~sda_q & sda;
    end
endmodule

// File: rtl/twi_addr_ptr.sv
// Persistent auto-incrementing address pointer; load wins over increment.
// Assumes: wrap at 2**W is the intended roll-over.
module twi_addr_ptr #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] ptr
);
    // Hold, load or advance the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (load) ptr <= load_val;
        else if (inc)  ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/dual_id_twi_slave.sv
// Two-wire slave serving a byte memory and an RTC register file under two
// identifiers with one shared device-select field and separate pointers.
// Assumes: read ports return data one cycle after their read strobe; SCL
// phases last longer than the filter latency plus three clocks.
module dual_id_twi_slave
    import twi_pkg::*;
#(
    parameter int FILT_CYCLES = 3,
    parameter int MEM_AW      = 15,
    parameter int RTC_AW      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic [2:0]        dev_sel,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_wr,
    output logic              mem_rd,
    input  logic [7:0]        mem_rdata,
    output logic [RTC_AW-1:0] rtc_addr,
    output logic              rtc_wr,
    output logic              rtc_rd,
    input  logic [7:0]        rtc_rdata,
    output logic [7:0]        wr_data
);
    localparam int HI_W = MEM_AW - BYTE_W;

    logic [1:0] raw_lines, clean_lines;
    logic       scl_f, sda_f;
    logic       scl_rise, scl_fall, start_evt, stop_evt;

    assign raw_lines = {sda_i, scl_i};

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_filt
            twi_line_filter #(.STABLE(FILT_CYCLES)) u_filt (
                .clk(clk), .rst_n(rst_n),
                .raw(raw_lines[g]), .clean(clean_lines[g])
            );
        end
    endgenerate

    assign scl_f = clean_lines[0];
    assign sda_f = clean_lines[1];

    twi_bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    phase_t          phase;
    stage_t          stage;
    logic [3:0]      bitcnt;
    logic [7:0]      shreg, wdata_q;
    logic [HI_W-1:0] hi_byte;
    logic            is_rtc, is_read, oe_q, mack_q;
    logic            mem_wr_q, rtc_wr_q, mem_rd_q, rtc_rd_q;

    logic [7:0]  rx_byte, rd_byte;
    logic        byte_end, tx_end, id_match;
    logic        mem_load, rtc_load, mem_inc, rtc_inc;

    // Byte assembly, event qualification and pointer control.
    always_comb begin
        rx_byte  = {shreg[6:0], sda_f};
        rd_byte  = is_rtc ? rtc_rdata : mem_rdata;
        byte_end = pwr_good && (phase == PH_RX) && scl_rise && (bitcnt == 4'd7);
        tx_end   = pwr_good && (phase == PH_TX) && scl_fall && (bitcnt == 4'd7);
        id_match = (rx_byte[3:1] == dev_sel) &&
                   ((rx_byte[7:4] == ID_MEM) || (rx_byte[7:4] == ID_RTC));
        mem_load = byte_end && (stage == ST_ALO) && !is_rtc;
        rtc_load = byte_end && (stage == ST_ALO) && is_rtc;
        mem_inc  = mem_wr_q || (tx_end && !is_rtc);
        rtc_inc  = rtc_wr_q || (tx_end && is_rtc);
    end

    twi_addr_ptr #(.W(MEM_AW)) u_mem_ptr (
        .clk(clk), .rst_n(rst_n), .load(mem_load),
        .load_val({hi_byte, rx_byte}), .inc(mem_inc), .ptr(mem_addr)
    );

    twi_addr_ptr #(.W(RTC_AW)) u_rtc_ptr (
        .clk(clk), .rst_n(rst_n), .load(rtc_load),
        .load_val(rx_byte[RTC_AW-1:0]), .inc(rtc_inc), .ptr(rtc_addr)
    );

    // Protocol state machine: receive, acknowledge, fetch and transmit.
    always_ff @(posedge clk) begin
        mem_wr_q <= 1'b0;
        rtc_wr_q <= 1'b0;
        mem_rd_q <= 1'b0;
        rtc_rd_q <= 1'b0;
        if (!rst_n) begin
            phase   <= PH_IDLE;
            stage   <= ST_DEV;
            bitcnt  <= '0;
            shreg   <= '0;
            wdata_q <= '0;
            hi_byte <= '0;
            is_rtc  <= 1'b0;
            is_read <= 1'b0;
            oe_q    <= 1'b0;
            mack_q  <= 1'b0;
        end else if (!pwr_good || stop_evt) begin
            phase <= PH_IDLE;
            oe_q  <= 1'b0;
        end else if (start_evt) begin
            phase  <= PH_RX;
            stage  <= ST_DEV;
            bitcnt <= '0;
            oe_q   <= 1'b0;
        end else begin
            case (phase)
                PH_RX: begin
                    if (scl_rise && bitcnt < 4'd8) begin
                        shreg  <= rx_byte;
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == 4'd7) begin
                            case (stage)
                                ST_DEV: begin
                                    if (id_match) begin
                                        is_rtc  <= (rx_byte[7:4] == ID_RTC);
                                        is_read <= rx_byte[0];
                                    end else begin
                                        phase <= PH_IDLE;
                                    end
                                end
                                ST_AHI:  hi_byte <= rx_byte[HI_W-1:0];
                                ST_DATA: begin
                                    wdata_q  <= rx_byte;
                                    mem_wr_q <= !is_rtc;
                                    rtc_wr_q <= is_rtc;
                                end
                                default: ;
                            endcase
                        end
                    end else if (scl_fall && bitcnt == 4'd8) begin
                        phase <= PH_ACK;
                        oe_q  <= 1'b1;
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        oe_q <= 1'b0;
                        if (stage == ST_DEV && is_read) begin
                            phase    <= PH_LOAD;
                            mem_rd_q <= !is_rtc;
                            rtc_rd_q <= is_rtc;
                        end else begin
                            phase  <= PH_RX;
                            bitcnt <= '0;
                            case (stage)
                                ST_DEV:  stage <= is_rtc ? ST_ALO : ST_AHI;
                                ST_AHI:  stage <= ST_ALO;
                                default: stage <= ST_DATA;
                            endcase
                        end
                    end
                end
                PH_LOAD:  phase <= PH_FETCH;
                PH_FETCH: begin
                    shreg  <= rd_byte;
                    oe_q   <= ~rd_byte[7];
                    bitcnt <= '0;
                    phase  <= PH_TX;
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            oe_q  <= 1'b0;
                            phase <= PH_MACK;
                        end else begin
                            shreg  <= {shreg[6:0], 1'b0};
                            oe_q   <= ~shreg[6];
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                PH_MACK: begin
                    if (scl_rise) begin
                        mack_q <= ~sda_f;
                    end else if (scl_fall) begin
                        if (mack_q) begin
                            phase    <= PH_LOAD;
                            mem_rd_q <= !is_rtc;
                            rtc_rd_q <= is_rtc;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe  = oe_q;
    assign mem_wr  = mem_wr_q;
    assign rtc_wr  = rtc_wr_q;
    assign mem_rd  = mem_rd_q;
    assign rtc_rd  = rtc_rd_q;
    assign wr_data = wdata_q;

    // R10
    pwr_off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !sda_oe);

    // R5
    mem_wr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (mem_addr == $past(mem_addr) + 1'b1));

    // R5
    rtc_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rtc_wr || rtc_rd) |=> $stable(mem_addr));

    // R8
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !sda_oe);

    // R9
    oe_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_f);

    // R6
    write_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr || rtc_wr) |-> $past(scl_rise));
endmodule

// File: tb/test_dual_id_twi_slave.sv
module test_dual_id_twi_slave;
    localparam int Q = 14;
    localparam logic [2:0] SEL   = 3'b101;
    localparam logic [7:0] MEM_W = {4'b1010, SEL, 1'b0};
    localparam logic [7:0] MEM_R = {4'b1010, SEL, 1'b1};
    localparam logic [7:0] RTC_W = {4'b1101, SEL, 1'b0};
    localparam logic [7:0] RTC_R = {4'b1101, SEL, 1'b1};
    localparam int NV = 8;
    // op: 0 mem write, 1 rtc write, 2 mem random read, 3 rtc random read
    localparam logic [25:0] VEC [NV] = '{
        {2'd0, 16'h0123, 8'h5A},
        {2'd0, 16'h7FFE, 8'hC3},
        {2'd1, 16'h0005, 8'h17},
        {2'd0, 16'h0124, 8'hA5},
        {2'd3, 16'h0005, 8'h17},
        {2'd2, 16'h0123, 8'h5A},
        {2'd2, 16'h7FFE, 8'hC3},
        {2'd2, 16'h0124, 8'hA5}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b1;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_line, sda_oe;
    logic [14:0] mem_addr;
    logic [3:0]  rtc_addr;
    logic mem_wr, mem_rd, rtc_wr, rtc_rd;
    logic [7:0] mem_rdata = 8'h00, rtc_rdata = 8'h00, wr_data;

    int n_chk = 0, n_err = 0;
    int mem_wr_cnt = 0, mem_rd_cnt = 0, rtc_wr_cnt = 0, rtc_rd_cnt = 0;
    int r9_viol = 0;
    logic oe_prev = 1'b0;
    bit all_ack;

    logic [7:0] mem_store [int];
    logic [7:0] rtc_store [int];

    always #5 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    dual_id_twi_slave i_dual_id_twi_slave (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .dev_sel(SEL),
        .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .rtc_addr(rtc_addr), .rtc_wr(rtc_wr), .rtc_rd(rtc_rd), .rtc_rdata(rtc_rdata),
        .wr_data(wr_data)
    );

    // Port-side storage models with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_wr) mem_store[int'(mem_addr)] = wr_data;
        if (rtc_wr) rtc_store[int'(rtc_addr)] = wr_data;
        if (mem_rd) mem_rdata <= mem_store.exists(int'(mem_addr)) ? mem_store[int'(mem_addr)] : 8'hEE;
        if (rtc_rd) rtc_rdata <= rtc_store.exists(int'(rtc_addr)) ? rtc_store[int'(rtc_addr)] : 8'hEE;
    end

    // Strobe counters and the R9 monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_wr) mem_wr_cnt++;
            if (mem_rd) mem_rd_cnt++;
            if (rtc_wr) rtc_wr_cnt++;
            if (rtc_rd) rtc_rd_cnt++;
            if (m_scl && sda_oe != oe_prev) r9_viol++;
        end
        oe_prev = sda_oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wq(); m_scl = 1'b1; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
        if (sda_line) all_ack = 1'b0;
        m_scl = 1'b0; wq();
    endtask

    task automatic recv_byte(output logic [7:0] d, input bit ack);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); m_scl = 1'b1; wq(); d[i] = sda_line; m_scl = 1'b0;
        end
        wq(); m_sda = ack ? 1'b0 : 1'b1; wq(); m_scl = 1'b1; wq(); m_scl = 1'b0; m_sda = 1'b1;
    endtask

    task automatic mem_write(input logic [15:0] a, input logic [7:0] d);
        all_ack = 1'b1;
        bus_start(); send_byte(MEM_W); send_byte(a[15:8]); send_byte(a[7:0]); send_byte(d); bus_stop();
    endtask

    task automatic rtc_write(input logic [7:0] a, input logic [7:0] d);
        all_ack = 1'b1;
        bus_start(); send_byte(RTC_W); send_byte(a); send_byte(d); bus_stop();
    endtask

    task automatic mem_read1(input logic [15:0] a, output logic [7:0] d);
        all_ack = 1'b1;
        bus_start(); send_byte(MEM_W); send_byte(a[15:8]); send_byte(a[7:0]);
        bus_start(); send_byte(MEM_R); recv_byte(d, 1'b0); bus_stop();
    endtask

    task automatic rtc_read1(input logic [7:0] a, output logic [7:0] d);
        all_ack = 1'b1;
        bus_start(); send_byte(RTC_W); send_byte(a);
        bus_start(); send_byte(RTC_R); recv_byte(d, 1'b0); bus_stop();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        logic [7:0] d0, d1;
        int cnt0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(sda_oe == 1'b0, "R11 sda_oe", int'(sda_oe), 0);
        chk(mem_addr == 15'd0, "R11 mem_addr", int'(mem_addr), 0);
        chk(rtc_addr == 4'd0, "R11 rtc_addr", int'(rtc_addr), 0);
        chk((mem_wr | mem_rd | rtc_wr | rtc_rd) == 1'b0, "R11 strobes", 1, 0);
        wq();

        // Vector walk: R1 acknowledge, R3/R4 addressing, R8 random reads
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [15:0] a;
            logic [7:0]  d, got;
            op = VEC[i][25:24]; a = VEC[i][23:8]; d = VEC[i][7:0];
            case (op)
                2'd0: begin mem_write(a, d); chk(all_ack, "R1 mem write ack", 0, 1); end
                2'd1: begin rtc_write(a[7:0], d); chk(all_ack, "R1 rtc write ack", 0, 1); end
                2'd2: begin mem_read1(a, got); chk(got == d, "R8 mem random read", int'(got), int'(d)); end
                default: begin rtc_read1(a[7:0], got); chk(got == d, "R8 rtc random read", int'(got), int'(d)); end
            endcase
        end

        // R3 wrap from 7FFFh to 0000h during a burst write
        all_ack = 1'b1;
        bus_start(); send_byte(MEM_W); send_byte(8'h7F); send_byte(8'hFF);
        send_byte(8'h11); send_byte(8'h22); bus_stop();
        mem_read1(16'h0000, d0);
        chk(d0 == 8'h22, "R3 wrap to 0000", int'(d0), 8'h22);
        mem_read1(16'h7FFF, d0);
        chk(d0 == 8'h11, "R3 last address", int'(d0), 8'h11);
        // R3 top address bit ignored
        mem_read1(16'h8123, d0);
        chk(d0 == 8'h5A, "R3 top bit ignored", int'(d0), 8'h5A);
        // R4 upper nibble of RTC address ignored
        rtc_read1(8'hF5, d0);
        chk(d0 == 8'h17, "R4 upper nibble ignored", int'(d0), 8'h17);

        // R7 sequential read continues on acknowledge, ends on not-acknowledge
        mem_write(16'h0125, 8'h3C);
        cnt0 = mem_rd_cnt;
        bus_start(); send_byte(MEM_W); send_byte(8'h01); send_byte(8'h23);
        bus_start(); send_byte(MEM_R); recv_byte(d0, 1'b1); recv_byte(d1, 1'b0);
        wq(); wq();
        chk(sda_oe == 1'b0, "R7 released after nack", int'(sda_oe), 0);
        bus_stop();
        chk(d0 == 8'h5A && d1 == 8'hA5, "R7 sequential data", int'({d0, d1}), 16'h5AA5);
        chk(mem_rd_cnt - cnt0 == 2, "R7 read strobe count", mem_rd_cnt - cnt0, 2);

        // R5 pointers advance per byte and stay independent
        rtc_write(8'h02, 8'h44);
        chk(mem_addr == 15'h0125, "R5 mem pointer kept", int'(mem_addr), 15'h0125);
        chk(rtc_addr == 4'd3, "R5 rtc pointer advanced", int'(rtc_addr), 3);
        bus_start(); send_byte(MEM_R); recv_byte(d0, 1'b0); bus_stop();
        chk(d0 == 8'h3C, "R5 current address read", int'(d0), 8'h3C);

        // R2 device-select mismatch and unknown identifier
        cnt0 = mem_wr_cnt + rtc_wr_cnt + mem_rd_cnt + rtc_rd_cnt;
        all_ack = 1'b1;
        bus_start(); send_byte({4'b1010, SEL ^ 3'b001, 1'b0}); send_byte(8'h00); send_byte(8'h00);
        send_byte(8'h99); bus_stop();
        chk(!all_ack, "R2 select mismatch nack", int'(all_ack), 0);
        chk(mem_wr_cnt + rtc_wr_cnt + mem_rd_cnt + rtc_rd_cnt == cnt0, "R2 no strobe",
            mem_wr_cnt + rtc_wr_cnt + mem_rd_cnt + rtc_rd_cnt, cnt0);
        all_ack = 1'b1;
        bus_start(); send_byte({4'b0101, SEL, 1'b0}); bus_stop();
        chk(!all_ack, "R2 unknown id nack", int'(all_ack), 0);

        // R6 start before the eighth data bit discards the byte
        cnt0 = mem_wr_cnt;
        bus_start(); send_byte(MEM_W); send_byte(8'h02); send_byte(8'h00);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_start(); bus_stop();
        chk(mem_wr_cnt == cnt0, "R6 no write strobe", mem_wr_cnt, cnt0);
        mem_read1(16'h0200, d0);
        chk(d0 == 8'hEE, "R6 location untouched", int'(d0), 8'hEE);

        // R10 bus ignored while power is not good
        pwr_good = 1'b0;
        mem_write(16'h0300, 8'h99);
        chk(!all_ack, "R10 no ack without power", int'(all_ack), 0);
        pwr_good = 1'b1;
        wq();
        mem_read1(16'h0300, d0);
        chk(d0 == 8'hEE, "R10 no write without power", int'(d0), 8'hEE);

        // R9 output only changes while SCL is low
        chk(r9_viol == 0, "R9 oe change during SCL high", r9_viol, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule